// File: doc/BRIEF.md
# Guarded TLB with Multi-Match Shutdown

The block is a small fully associative address translation buffer with sixteen entries. A lookup takes a 32-bit virtual address and an 8-bit address-space identifier. In the same cycle it reports exactly one outcome: a hit with a physical frame number, a miss, a multi-match, an unmapped bypass, or a disabled result. An entry is loaded by one of two ports that share one data bus. The indexed port writes the slot named by an explicit index. The random port writes the slot named by a free-running counter.

The block guards against entries that overlap. If a lookup matches more than one entry, the block moves from state `ST_RUN` to state `ST_HALT` on the next clock edge. The only transition is `ST_RUN -> ST_HALT`, taken on a multi-match. `ST_HALT` has no exit other than reset, so the shutdown bit is sticky. Writes are also checked: loading an entry whose tag and identifier already sit in another valid slot raises a duplicate warning in the cycle of the write. After reset, every slot holds a distinct parking tag from the unmapped upper half of the address space, with a zero mask. A slot that has never been written can therefore never match, and a read-out port can identify it.

Top module: `tlb_sentinel`

## Requirements
- R1: After reset `ts` is 0. Slot i reads back a tag field of 0x40000+i, which is bits 31:13 of 0x80000000+(i<<13). It reads back a zero mask and `rd_unused`=1. No lookup of an address with bit 31 clear matches an unwritten slot.
- R2: A slot matches when (`lk_va[31:13]` AND slot mask) equals the slot tag and the slot identifier equals `lk_asid`. On exactly one match, `lk_hit`=1 and `lk_pfn` is that slot's frame, in the same cycle.
- R3: Every cycle with `lk_en`=1 asserts exactly one of `lk_hit`, `lk_miss`, `lk_multi`, `lk_bypass` and `lk_disabled`. In `ST_RUN` with no match, the outcome is `lk_miss`.
- R4: In `ST_RUN`, a lookup with `lk_va[31]`=1 gives `lk_bypass`=1 and `lk_pfn`={3'b000, `lk_va[28:12]`}. Such a lookup never causes a shutdown.
- R5: In `ST_RUN`, two or more matches give `lk_multi`=1 in the same cycle, with `lk_hit`=0 and `lk_miss`=0. `ts` becomes 1 after the next rising edge.
- R6: Once `ts`=1 it remains 1 through any writes and lookups until `rst_n` is low.
- R7: While `ts`=1, every lookup gives only `lk_disabled`=1, with `lk_pfn`=0. This includes bypass addresses.
- R8: Writes never change `ts`, even when a write creates overlapping slots. Only a lookup can start the shutdown.
- R9: `wi_en` writes the slot `wi_idx` at the clock edge. When `wi_en` and `wr_en` are both high, only the indexed slot is written.
- R10: `rnd_idx` is 0 in reset and advances by one on every clock edge, wrapping from 15 to 0. `wr_en` alone writes the slot that `rnd_idx` shows during that cycle.
- R11: `wr_dup`=1 during a write cycle exactly when another slot has been written since reset and holds the same tag and identifier. The target slot itself never counts as a duplicate.
- R12: The read-out port returns the tag, mask, identifier and frame of slot `rd_idx` combinationally. `rd_unused` is 1 exactly when that mask is zero. The read-out works in both states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Single match |
| lk_miss | output | 1 | No match |
| lk_multi | output | 1 | Two or more matches |
| lk_bypass | output | 1 | Unmapped address, not translated |
| lk_disabled | output | 1 | Lookup refused after shutdown |
| lk_pfn | output | 20 | Physical frame number |
| wi_en | input | 1 | Indexed write strobe |
| wi_idx | input | 4 | Indexed write slot |
| wr_en | input | 1 | Random write strobe |
| w_vpn2 | input | 19 | Write data: tag (address bits 31:13) |
| w_mask | input | 19 | Write data: compare mask |
| w_asid | input | 8 | Write data: identifier |
| w_pfn | input | 20 | Write data: frame number |
| wr_dup | output | 1 | Duplicate tag/identifier on this write |
| rnd_idx | output | 4 | Current random write slot |
| rd_idx | input | 4 | Read-out slot |
| rd_vpn2 | output | 19 | Read-out tag |
| rd_mask | output | 19 | Read-out mask |
| rd_asid | output | 8 | Read-out identifier |
| rd_pfn | output | 20 | Read-out frame number |
| rd_unused | output | 1 | Read-out slot has a zero mask |
| ts | output | 1 | Sticky shutdown status |

## Verification
The in-design properties check five things on every cycle. A lookup gives exactly one outcome. A multi-match is followed by shutdown, and shutdown has no other cause. Shutdown is sticky and blocks every other outcome. The random slot counter steps by one and wraps, and unwritten slots never raise a comparator hit. Some behaviour can only be shown by the bench's scenarios, which carry a model of the slots. These are the exact frame returned under partial masks, the parking tags after reset, duplicate detection against other slots but not against the target, write priority, and the restoration of the parking tags by a hard reset.

// File: rtl/tlb_sentinel_pkg.sv
package tlb_sentinel_pkg;
    parameter int ENTRIES    = 16;
    parameter int VA_W       = 32;
    parameter int PAGE_SHIFT = 12;
    parameter int ASID_W     = 8;
    parameter int PFN_W      = 20;
    parameter int SEG_BITS   = 3;

    localparam int VPN2_W  = VA_W - PAGE_SHIFT - 1;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int CNT_W   = $clog2(ENTRIES + 1);
    localparam int SEG_TOP = VA_W - 1 - SEG_BITS;
    localparam logic [VA_W-1:0] PARK_BASE = {1'b1, {(VA_W-1){1'b0}}};

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [VPN2_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
    } tlb_entry_t;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } tlb_state_e;

    // Distinct tag in the unmapped region for each slot index.
    function automatic logic [VPN2_W-1:0] park_tag(input int unsigned idx);
        logic [VA_W-1:0] addr;
        addr = PARK_BASE + (VA_W'(idx) << (PAGE_SHIFT + 1));
        return addr[VA_W-1 -: VPN2_W];
    endfunction
endpackage

// File: rtl/tlb_sentinel_store.sv
module tlb_sentinel_store
    import tlb_sentinel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  tlb_entry_t        wdata,
    output tlb_entry_t        ent   [ENTRIES],
    output logic [ENTRIES-1:0] valid
);
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[g]   <= '{vpn2: park_tag(int'(g)), mask: '0, asid: '0, pfn: '0};
                    valid[g] <= 1'b0;
                end else if (we && (widx == IDX_W'(g))) begin
                    ent[g]   <= wdata;
                    valid[g] <= 1'b1;
                end
            end

            // R9: a write to this slot leaves it marked as loaded
            a_r9_slot_loaded: assert property (@(posedge clk) disable iff (!rst_n)
                (we && (widx == IDX_W'(g))) |=> valid[g]);
        end
    endgenerate
endmodule

// File: rtl/tlb_sentinel_match.sv
module tlb_sentinel_match
    import tlb_sentinel_pkg::*;
(
    input  tlb_entry_t         ent  [ENTRIES],
    input  logic [VPN2_W-1:0]  vpn2,
    input  logic [ASID_W-1:0]  asid,
    output logic [ENTRIES-1:0] hits,
    output logic [CNT_W-1:0]   nhits,
    output logic [PFN_W-1:0]   pfn
);
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hits[g] = ((vpn2 & ent[g].mask) == ent[g].vpn2) &&
                             (ent[g].asid == asid);
        end
    endgenerate

    // Population count and lowest-index frame select.
    always_comb begin
        nhits = '0;
        pfn   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                nhits = nhits + CNT_W'(1);
                pfn   = ent[i].pfn;
            end
        end
    end
endmodule

// File: rtl/tlb_sentinel_dup.sv
module tlb_sentinel_dup
    import tlb_sentinel_pkg::*;
(
    input  tlb_entry_t         ent  [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [VPN2_W-1:0]  wvpn2,
    input  logic [ASID_W-1:0]  wasid,
    output logic               dup
);
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (we && valid[i] && (widx != IDX_W'(i)) &&
                (ent[i].vpn2 == wvpn2) && (ent[i].asid == wasid)) begin
                dup = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_sentinel.sv
module tlb_sentinel
    import tlb_sentinel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_multi,
    output logic              lk_bypass,
    output logic              lk_disabled,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              wi_en,
    input  logic [IDX_W-1:0]  wi_idx,
    input  logic              wr_en,
    input  logic [VPN2_W-1:0] w_vpn2,
    input  logic [VPN2_W-1:0] w_mask,
    input  logic [ASID_W-1:0] w_asid,
    input  logic [PFN_W-1:0]  w_pfn,
    output logic              wr_dup,
    output logic [IDX_W-1:0]  rnd_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [VPN2_W-1:0] rd_vpn2,
    output logic [VPN2_W-1:0] rd_mask,
    output logic [ASID_W-1:0] rd_asid,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic              rd_unused,
    output logic              ts
);
    tlb_state_e          state_q, state_d;
    logic [IDX_W-1:0]    rnd_q;
    tlb_entry_t          ent [ENTRIES];
    logic [ENTRIES-1:0]  valid;
    logic [ENTRIES-1:0]  hits;
    logic [CNT_W-1:0]    nhits;
    logic [PFN_W-1:0]    hit_pfn;
    logic                we;
    logic [IDX_W-1:0]    widx;
    tlb_entry_t          wdata;
    logic                unused_va_low;

    assign unused_va_low = ^lk_va[PAGE_SHIFT-1:0];

    // Write path: the indexed port wins over the random port.
    assign we    = wi_en | wr_en;
    assign widx  = wi_en ? wi_idx : rnd_q;
    assign wdata = '{vpn2: w_vpn2, mask: w_mask, asid: w_asid, pfn: w_pfn};

    tlb_sentinel_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .widx  (widx),
        .wdata (wdata),
        .ent   (ent),
        .valid (valid)
    );

    tlb_sentinel_match u_match (
        .ent   (ent),
        .vpn2  (lk_va[VA_W-1 -: VPN2_W]),
        .asid  (lk_asid),
        .hits  (hits),
        .nhits (nhits),
        .pfn   (hit_pfn)
    );

    tlb_sentinel_dup u_dup (
        .ent   (ent),
        .valid (valid),
        .we    (we),
        .widx  (widx),
        .wvpn2 (w_vpn2),
        .wasid (w_asid),
        .dup   (wr_dup)
    );

    // Free-running random slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_q <= '0;
        end else if (rnd_q == IDX_W'(ENTRIES - 1)) begin
            rnd_q <= '0;
        end else begin
            rnd_q <= rnd_q + IDX_W'(1);
        end
    end
    assign rnd_idx = rnd_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: only a multi-match lookup leaves ST_RUN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (lk_multi) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
        endcase
    end

    // Lookup outcome per state.
    always_comb begin
        lk_hit      = 1'b0;
        lk_miss     = 1'b0;
        lk_multi    = 1'b0;
        lk_bypass   = 1'b0;
        lk_disabled = 1'b0;
        lk_pfn      = '0;
        unique case (state_q)
            ST_RUN: begin
                if (lk_en) begin
                    if (lk_va[VA_W-1]) begin
                        lk_bypass = 1'b1;
                        lk_pfn    = PFN_W'(lk_va[SEG_TOP:PAGE_SHIFT]);
                    end else if (nhits == '0) begin
                        lk_miss = 1'b1;
                    end else if (nhits == CNT_W'(1)) begin
                        lk_hit = 1'b1;
                        lk_pfn = hit_pfn;
                    end else begin
                        lk_multi = 1'b1;
                    end
                end
            end
            ST_HALT: lk_disabled = lk_en;
        endcase
    end

    assign ts = (state_q == ST_HALT);

    // Debug read-out.
    assign rd_vpn2   = ent[rd_idx].vpn2;
    assign rd_mask   = ent[rd_idx].mask;
    assign rd_asid   = ent[rd_idx].asid;
    assign rd_pfn    = ent[rd_idx].pfn;
    assign rd_unused = (ent[rd_idx].mask == '0);

    // R1: comparators never fire for a slot not yet written
    a_r1_unwritten_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (hits & ~valid) == '0);

    // R3: one outcome per lookup
    a_r3_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |-> ($countones({lk_hit, lk_miss, lk_multi, lk_bypass, lk_disabled}) == 1));

    // R5: multi-match is followed by shutdown
    a_r5_multi_halts: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |=> ts);

    // R6: shutdown is sticky
    a_r6_ts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ts |=> ts);

    // R8: shutdown starts only from a lookup multi-match
    a_r8_ts_needs_multi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts) |-> $past(lk_multi));

    // R7: nothing but the disabled outcome while shut down
    a_r7_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ts |-> !(lk_hit || lk_miss || lk_multi || lk_bypass));

    // R10: random slot counter steps and wraps
    a_r10_rnd_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rnd_idx == (($past(rnd_idx) == IDX_W'(ENTRIES - 1)) ?
                               IDX_W'(0) : IDX_W'($past(rnd_idx) + IDX_W'(1)))));

    // R11: duplicate warning only during a write
    a_r11_dup_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dup |-> (wi_en || wr_en));
endmodule

// File: tb/tlb_sentinel_bench.sv
`timescale 1ns/1ps
module tlb_sentinel_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_en;
    logic [31:0] lk_va;
    logic [7:0]  lk_asid;
    logic        lk_hit, lk_miss, lk_multi, lk_bypass, lk_disabled;
    logic [19:0] lk_pfn;
    logic        wi_en, wr_en;
    logic [3:0]  wi_idx;
    logic [18:0] w_vpn2, w_mask;
    logic [7:0]  w_asid;
    logic [19:0] w_pfn;
    logic        wr_dup;
    logic [3:0]  rnd_idx, rd_idx;
    logic [18:0] rd_vpn2, rd_mask;
    logic [7:0]  rd_asid;
    logic [19:0] rd_pfn;
    logic        rd_unused, ts;

    int n_chk  = 0;
    int n_fail = 0;

    // Outcome code {hit, miss, multi, bypass, disabled}
    localparam logic [4:0] O_HIT = 5'b10000, O_MISS = 5'b01000, O_MULTI = 5'b00100,
                           O_BYP = 5'b00010, O_DIS  = 5'b00001;

    logic [18:0] m_vpn2 [16];
    logic [18:0] m_mask [16];
    logic [7:0]  m_asid [16];
    logic [19:0] m_pfn  [16];
    bit          m_halt;

    always #5 clk = ~clk;

    tlb_sentinel u_tlb_sentinel (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_bypass(lk_bypass),
        .lk_disabled(lk_disabled), .lk_pfn(lk_pfn), .wi_en(wi_en), .wi_idx(wi_idx),
        .wr_en(wr_en), .w_vpn2(w_vpn2), .w_mask(w_mask), .w_asid(w_asid), .w_pfn(w_pfn),
        .wr_dup(wr_dup), .rnd_idx(rnd_idx), .rd_idx(rd_idx), .rd_vpn2(rd_vpn2),
        .rd_mask(rd_mask), .rd_asid(rd_asid), .rd_pfn(rd_pfn), .rd_unused(rd_unused),
        .ts(ts)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic model_reset;
        for (int i = 0; i < 16; i++) begin
            m_vpn2[i] = 19'h40000 + 19'(i);
            m_mask[i] = '0;
            m_asid[i] = '0;
            m_pfn[i]  = '0;
        end
        m_halt = 1'b0;
    endtask

    function automatic logic [4:0] model(input logic [31:0] va, input logic [7:0] asid,
                                         output logic [19:0] pfn);
        int n;
        pfn = '0;
        if (m_halt) return O_DIS;
        if (va[31]) begin
            pfn = {3'b000, va[28:12]};
            return O_BYP;
        end
        n = 0;
        for (int i = 0; i < 16; i++) begin
            if (((va[31:13] & m_mask[i]) == m_vpn2[i]) && (m_asid[i] == asid)) begin
                n++;
                pfn = m_pfn[i];
            end
        end
        if (n == 0) return O_MISS;
        if (n > 1) begin
            pfn = '0;
            return O_MULTI;
        end
        return O_HIT;
    endfunction

    // Starts and ends at a falling edge.
    task automatic probe(input string req, input logic [31:0] va, input logic [7:0] asid);
        logic [19:0] ep;
        logic [4:0]  eo;
        eo = model(va, asid, ep);
        lk_en = 1'b1; lk_va = va; lk_asid = asid;
        #1;
        chk(req, 32'({lk_hit, lk_miss, lk_multi, lk_bypass, lk_disabled}), 32'(eo));
        chk(req, 32'(lk_pfn), 32'(ep));
        if (eo == O_MULTI) chk("R5 ts not yet set", 32'(ts), 32'd0);
        @(negedge clk);
        lk_en = 1'b0;
        if (eo == O_MULTI) m_halt = 1'b1;
    endtask

    task automatic write(input string req, input bit idxd, input bit rnd, input int idx,
                         input logic [18:0] v, input logic [18:0] m, input logic [7:0] a,
                         input logic [19:0] p, input bit exp_dup);
        int tgt;
        wi_en = idxd; wr_en = rnd; wi_idx = 4'(idx);
        w_vpn2 = v; w_mask = m; w_asid = a; w_pfn = p;
        #1;
        tgt = idxd ? idx : int'(rnd_idx);
        chk(req, 32'(wr_dup), 32'(exp_dup));
        @(negedge clk);
        wi_en = 1'b0; wr_en = 1'b0;
        m_vpn2[tgt] = v; m_mask[tgt] = m; m_asid[tgt] = a; m_pfn[tgt] = p;
        chk("R8 write keeps ts", 32'(ts), 32'(m_halt));
    endtask

    task automatic readout(input string req, input int i);
        rd_idx = 4'(i);
        #1;
        chk(req, 32'(rd_vpn2), 32'(m_vpn2[i]));
        chk(req, 32'(rd_mask), 32'(m_mask[i]));
        chk(req, 32'(rd_asid), 32'(m_asid[i]));
        chk(req, 32'(rd_pfn), 32'(m_pfn[i]));
        chk(req, 32'(rd_unused), 32'(m_mask[i] == '0));
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 counter in reset", 32'(rnd_idx), 32'd0);
        rst_n = 1'b1;
        model_reset();
        chk("R1 ts after reset", 32'(ts), 32'd0);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] prev;
        lk_en = 0; lk_va = '0; lk_asid = '0; wi_en = 0; wr_en = 0; wi_idx = '0;
        w_vpn2 = '0; w_mask = '0; w_asid = '0; w_pfn = '0; rd_idx = '0;
        @(negedge clk);
        do_reset();

        // R1/R12: parking tags and unused marks
        for (int i = 0; i < 16; i++) readout("R1 R12 parked slot", i);
        // R1/R3: nothing below the unmapped region hits
        for (int k = 0; k < 64; k++) probe("R1 R3 empty miss", {19'(k * 97), 13'(k)}, 8'(k & 3));
        // R4: bypass for unmapped addresses, including the parking tags
        for (int i = 0; i < 16; i++)
            probe("R4 bypass", 32'h8000_0000 + (32'(i) << 13) + 32'h123, 8'(i));
        probe("R4 bypass upper", 32'hBFFF_F000, 8'h00);
        chk("R4 no shutdown", 32'(ts), 32'd0);

        // R9/R11: fill all slots, no duplicates
        for (int i = 0; i < 16; i++)
            write("R9 R11 fill", 1'b1, 1'b0, i, 19'(i * 3 + 1), 19'h7FFFF, 8'(i),
                  20'h100 + 20'(i * 7), 1'b0);
        for (int i = 0; i < 16; i++) readout("R12 filled slot", i);
        // R2/R3: hits, wrong identifier misses, sweep of tags
        for (int i = 0; i < 16; i++) begin
            probe("R2 hit", {19'(i * 3 + 1), 13'h0ABC}, 8'(i));
            probe("R3 wrong asid", {19'(i * 3 + 1), 13'h0}, 8'(i + 100));
        end
        for (int k = 0; k < 64; k++) probe("R2 R3 sweep", {19'(k), 13'h0}, 8'(k % 16));

        // R2: partial mask covers sixteen tags
        write("R2 masked load", 1'b1, 1'b0, 5, 19'h00500, 19'h7FFF0, 8'd5, 20'hABCDE, 1'b0);
        for (int k = 0; k < 18; k++) probe("R2 masked", {19'h00500 + 19'(k), 13'h0}, 8'd5);

        // R11: rewriting the same slot is not a duplicate, another slot is
        write("R11 same slot", 1'b1, 1'b0, 5, 19'h00500, 19'h7FFF0, 8'd5, 20'hABCDE, 1'b0);
        write("R11 duplicate", 1'b1, 1'b0, 7, 19'd10, 19'h7FFFF, 8'd3, 20'h77777, 1'b1);
        chk("R8 overlap written, ts clear", 32'(ts), 32'd0);

        // R10: counter sequence and wrap
        prev = rnd_idx;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R10 counter step", 32'(rnd_idx), 32'(4'(prev + 4'd1)));
            prev = rnd_idx;
        end
        // R10: random write lands on the shown slot
        while (rnd_idx != 4'd12) @(negedge clk);
        write("R10 random write", 1'b0, 1'b1, 0, 19'h777, 19'h7FFFF, 8'd99, 20'h55555, 1'b0);
        readout("R10 slot 12", 12);
        probe("R10 random hit", {19'h777, 13'h0}, 8'd99);
        // R9: indexed wins when both strobes are high
        while (rnd_idx != 4'd13) @(negedge clk);
        write("R9 priority", 1'b1, 1'b1, 0, 19'h888, 19'h7FFFF, 8'd42, 20'h12345, 1'b0);
        readout("R9 slot 0", 0);
        readout("R9 slot 13 kept", 13);

        // R5: multi-match, then shutdown
        probe("R5 multi", {19'd10, 13'h0}, 8'd3);
        chk("R5 ts set", 32'(ts), 32'd1);
        // R7: only disabled while shut down
        probe("R7 disabled hit", {19'h888, 13'h0}, 8'd42);
        probe("R7 disabled bypass", 32'h8000_4000, 8'd0);
        probe("R7 disabled miss", 32'h0000_0000, 8'd200);
        // R6: writes cannot clear it
        write("R6 write in halt", 1'b1, 1'b0, 3, 19'h1234, 19'h7FFFF, 8'd3, 20'h1, 1'b0);
        repeat (5) @(negedge clk);
        chk("R6 ts sticky", 32'(ts), 32'd1);
        readout("R12 readout in halt", 3);

        // R1/R6: only reset clears, and slots return to parking tags
        do_reset();
        readout("R1 reparked 3", 3);
        readout("R1 reparked 7", 7);
        probe("R1 miss after reset", {19'd10, 13'h0}, 8'd3);

        summary();
        $finish;
    end
endmodule